// File: doc/BRIEF.md
# Three-Phase Gate-Drive Dead-Time Controller

This block is the digital control path in front of a three-phase half-bridge gate driver. Each phase has a high-side command and a low-side command. The block turns those commands into two gate-enable outputs per phase, six in total. It applies two global PWM gates and enforces lockout, so that the two switches of one phase are never on together. It also inserts a dead gap between one switch turning off and its complement turning on.

The gap comes from one of three sources, chosen by a 2-bit mode input. The first source is a count supplied on an input bus. The second is a fixed default length set by a parameter (300 cycles, which is 6 us at 50 MHz). The third is none at all: in that mode the outputs follow the commands edge for edge, and the external controller owns the timing. Only in that last mode can a cross-conduction enable let both switches of a phase be on at once.

Pulling the high-side PWM gate low chops the high sides. Every phase whose high command is set then moves to its low switch, which gives slow decay with synchronous rectification. Pulling the low-side PWM gate low removes every low-side drive. The command and PWM inputs are asynchronous and pass through a two-flop synchronizer. The mode, count and cross-conduction enable are treated as quasi-static configuration.

Top module: `gate_dt_ctrl`

## Requirements
- R1: While `rst_n` is low, all six gate outputs are low whatever the commands are.
- R2: A change on a command or PWM input reaches the outputs on the third rising clock edge after the change, and not earlier, when no dead-time wait applies.
- R3: `hi_cmd[i]` drives only `gate_hi[i]`, and `lo_cmd[i]` drives only `gate_lo[i]`; bit i is phase i.
- R4: `gate_hi[i]` and `gate_lo[i]` are never both high unless `dt_mode` is 2'b10 and `xcond_en` is high. In every other mode `xcond_en` has no effect.
- R5: When lockout is in force and both effective requests of a phase are high, both outputs of that phase go low.
- R6: In mode 2'b00 a switch turns on only after both outputs of its phase have been low for max(`dt_count`,1) consecutive cycles. When one output falls on edge n, the complement rises on edge n+max(`dt_count`,1).
- R7: In mode 2'b01, and in the reserved code 2'b11, the wait is the parameter `DEF_DT` (300 by default) and `dt_count` is ignored.
- R8: In mode 2'b10 no wait is added. When one side falls and the other side is requested, both changes happen on the same edge.
- R9: In mode 2'b10 with `xcond_en` high, both outputs of a phase may be on together. Dropping `xcond_en` makes the lockout of R5 apply again on the next edge.
- R10: If a turn-on request is withdrawn while it waits for its dead time, the output does not turn on.
- R11: While `pwm_hs_en` is low, every `gate_hi` is low. Each phase whose `hi_cmd` is high requests its low side instead, subject to the dead time.
- R12: While `pwm_ls_en` is low, every `gate_lo` is low, including the low sides that R11 would request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hi_cmd | input | 3 | High-side command, one bit per phase |
| lo_cmd | input | 3 | Low-side command, one bit per phase |
| pwm_hs_en | input | 1 | High-side PWM gate; low chops high sides into synchronous rectification |
| pwm_ls_en | input | 1 | Low-side PWM gate; low forces all low sides off |
| dt_mode | input | 2 | 00 count from `dt_count`, 01 fixed default, 10 no dead time, 11 as 01 |
| dt_count | input | 8 | Dead-time length in clock cycles for mode 00 |
| xcond_en | input | 1 | Allows both switches of a phase on together, mode 10 only |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |

## Verification
A dead-time counter that clears or saturates wrongly shows up at the ports as a complementary turn-on that comes one or more cycles early or late. The bench sees this within dead time plus three cycles of the command change, because it samples the exact edge on which the complement must rise and the edge before it. A grant register stuck high, or a lockout term that is missing, shows up as an overlap of `gate_hi` and `gate_lo` on the very next edge. A continuous monitor also measures every off-to-complement gap against the selected mode. A mix-up in the effective-request terms shows up as a wrong side turning on three edges after a PWM gate changes.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

  typedef enum logic [1:0] {
    DT_PROG = 2'b00,
    DT_DEF  = 2'b01,
    DT_OFF  = 2'b10,
    DT_RSV  = 2'b11
  } dt_mode_e;

endpackage

// File: rtl/gdt_rst_sync.sv
module gdt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n_out = rst_pipe_q[1];

endmodule

// File: rtl/gdt_sync2.sv
module gdt_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_in;
      stab_q <= meta_q;
    end
  end

  assign q_out = stab_q;

endmodule

// File: rtl/gdt_phase.sv
module gdt_phase
  import gdt_pkg::*;
#(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_hi,
  input  logic          cmd_lo,
  input  logic          pwm_hs,
  input  logic          pwm_ls,
  input  dt_mode_e      mode,
  input  logic [CW-1:0] dt_len,
  input  logic          xcond_en,
  output logic          gate_hi,
  output logic          gate_lo
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          gh_q, gl_q, gh_d, gl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          want_h, want_l;
  logic          pass_thru, allow_both, clash, ready, idle;

  // effective requests after the PWM gates
  always_comb begin
    want_h     = cmd_hi & pwm_hs;
    want_l     = (cmd_lo | (cmd_hi & ~pwm_hs)) & pwm_ls;
    pass_thru  = (mode == DT_OFF);
    allow_both = pass_thru & xcond_en;
    clash      = want_h & want_l & ~allow_both;
    ready      = (cnt_q >= dt_len);
    idle       = ~gh_q & ~gl_q;
  end

  // grant next state
  always_comb begin
    if (pass_thru) begin
      gh_d = want_h & ~clash;
      gl_d = want_l & ~clash;
    end else if (idle) begin
      gh_d = ready & want_h & ~clash;
      gl_d = ready & want_l & ~clash;
    end else begin
      gh_d = gh_q & want_h & ~clash;
      gl_d = gl_q & want_l & ~clash;
    end
  end

  // off-time counter next state, saturating
  always_comb begin
    if (gh_d | gl_d) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = (cnt_q != CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gh_q <= 1'b0;
      gl_q <= 1'b0;
    end else begin
      gh_q <= gh_d;
      gl_q <= gl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign gate_hi = gh_q;
  assign gate_lo = gl_q;

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (gh_q && gl_q) |-> ($past(mode) == DT_OFF && $past(xcond_en))); // R4

  AST_CLASH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (want_h && want_l && !(mode == DT_OFF && xcond_en)) |=> (!gh_q && !gl_q)); // R5

  AST_LO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gl_q) && $past(mode) != DT_OFF) |-> $past(!gh_q)); // R6

  AST_HI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gh_q) && $past(mode) != DT_OFF) |-> $past(!gl_q)); // R6

endmodule

// File: rtl/gate_dt_ctrl.sv
module gate_dt_ctrl
  import gdt_pkg::*;
#(
  parameter int NPH    = 3,
  parameter int DT_W   = 8,
  parameter int DEF_DT = 300
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPH-1:0]  hi_cmd,
  input  logic [NPH-1:0]  lo_cmd,
  input  logic            pwm_hs_en,
  input  logic            pwm_ls_en,
  input  logic [1:0]      dt_mode,
  input  logic [DT_W-1:0] dt_count,
  input  logic            xcond_en,
  output logic [NPH-1:0]  gate_hi,
  output logic [NPH-1:0]  gate_lo
);

  localparam int DEF_W = $clog2(DEF_DT + 1);
  localparam int CW    = (DT_W > DEF_W) ? DT_W : DEF_W;
  localparam int SW    = 2 * NPH + 2;

  logic           rst_int_n;
  logic [SW-1:0]  raw_in, sync_out;
  logic [NPH-1:0] hi_s, lo_s;
  logic           pwm_hs_s, pwm_ls_s;
  dt_mode_e       mode_e;
  logic [CW-1:0]  dt_len;

  gdt_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_int_n)
  );

  assign raw_in = {pwm_ls_en, pwm_hs_en, lo_cmd, hi_cmd};

  gdt_sync2 #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  (raw_in),
    .q_out (sync_out)
  );

  assign hi_s     = sync_out[NPH-1:0];
  assign lo_s     = sync_out[2*NPH-1:NPH];
  assign pwm_hs_s = sync_out[2*NPH];
  assign pwm_ls_s = sync_out[2*NPH+1];

  always_comb begin
    mode_e = dt_mode_e'(dt_mode);
    case (mode_e)
      DT_PROG: dt_len = CW'(dt_count);
      DT_OFF:  dt_len = '0;
      default: dt_len = CW'(DEF_DT);
    endcase
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    gdt_phase #(.CW(CW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .cmd_hi   (hi_s[p]),
      .cmd_lo   (lo_s[p]),
      .pwm_hs   (pwm_hs_s),
      .pwm_ls   (pwm_ls_s),
      .mode     (mode_e),
      .dt_len   (dt_len),
      .xcond_en (xcond_en),
      .gate_hi  (gate_hi[p]),
      .gate_lo  (gate_lo[p])
    );
  end

  AST_HS_CHOP: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pwm_hs_s |=> (gate_hi == '0)); // R11

  AST_LS_KILL: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pwm_ls_s |=> (gate_lo == '0)); // R12

endmodule

// File: tb/gate_dt_ctrl_tb_top.sv
module gate_dt_ctrl_tb_top;

  localparam int DEF = 300;

  logic       clk, rst_n;
  logic [2:0] hi_cmd, lo_cmd;
  logic       pwm_hs_en, pwm_ls_en, xcond_en;
  logic [1:0] dt_mode;
  logic [7:0] dt_count;
  logic [2:0] gate_hi, gate_lo;

  gate_dt_ctrl #(.NPH(3), .DT_W(8), .DEF_DT(DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .pwm_hs_en(pwm_hs_en), .pwm_ls_en(pwm_ls_en), .dt_mode(dt_mode),
    .dt_count(dt_count), .xcond_en(xcond_en),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    int unsigned due;
    logic [2:0]  eh;
    logic [2:0]  el;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic [2:0] h, logic [2:0] l);
    hi_cmd = h;
    lo_cmd = l;
  endtask

  task automatic expect_at(int n, logic [2:0] eh, logic [2:0] el, string tag);
    exp_t e;
    e.due = cyc + n;
    e.eh  = eh;
    e.el  = el;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  function automatic int min_gap();
    case (dt_mode)
      2'b00:   return (dt_count == 0) ? 1 : int'(dt_count);
      2'b10:   return 0;
      default: return DEF;
    endcase
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // scoreboard monitor and gap monitor
  int         idle_run[3];
  int         last_on[3];
  logic [2:0] prev_h = '0, prev_l = '0;

  initial begin
    for (int i = 0; i < 3; i++) begin
      idle_run[i] = 0;
      last_on[i]  = 0;
    end
  end

  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (gate_hi !== e.eh || gate_lo !== e.el) begin
        errors++;
        $display("FAIL %s: actual hi=%b lo=%b expected hi=%b lo=%b",
                 e.tag, gate_hi, gate_lo, e.eh, e.el);
      end
    end
    if (rst_n) begin
      for (int p = 0; p < 3; p++) begin
        if (dt_mode != 2'b10 && gate_hi[p] && gate_lo[p]) begin
          checks++;
          errors++;
          $display("FAIL R4 overlap phase %0d: actual both=1 expected not both", p);
        end
        if ((gate_hi[p] && !prev_h[p] && last_on[p] == 2) ||
            (gate_lo[p] && !prev_l[p] && last_on[p] == 1)) begin
          checks++;
          if (idle_run[p] < min_gap()) begin
            errors++;
            $display("FAIL R6/R7 gap phase %0d: actual %0d expected >= %0d",
                     p, idle_run[p], min_gap());
          end
        end
        if (gate_hi[p] || gate_lo[p]) begin
          idle_run[p] = 0;
          if (!(gate_hi[p] && gate_lo[p])) last_on[p] = gate_hi[p] ? 1 : 2;
        end else begin
          idle_run[p] = idle_run[p] + 1;
        end
      end
    end
    prev_h = gate_hi;
    prev_l = gate_lo;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hi_cmd = 3'b111; lo_cmd = 3'b000;
    pwm_hs_en = 1'b1; pwm_ls_en = 1'b1; xcond_en = 1'b0;
    dt_mode = 2'b00; dt_count = 8'd5;
    tick(1);
    expect_at(3, 3'b000, 3'b000, "R1 reset quiet");
    tick(4);
    rst_n = 1'b1; drive(3'b000, 3'b000);
    tick(30);

    // R2 latency and R3 mapping
    drive(3'b001, 3'b000);
    expect_at(2, 3'b000, 3'b000, "R2 not before third edge");
    expect_at(3, 3'b001, 3'b000, "R3 high maps to phase0 high");
    tick(10);

    // R6 programmed dead time, D=5
    drive(3'b000, 3'b001);
    expect_at(3, 3'b000, 3'b000, "R6 high off");
    expect_at(7, 3'b000, 3'b000, "R6 still waiting");
    expect_at(8, 3'b000, 3'b001, "R6 low on after D");
    tick(12);

    // R10 withdrawn request
    drive(3'b001, 3'b000);
    expect_at(3, 3'b000, 3'b000, "R10 low off");
    tick(3);
    drive(3'b000, 3'b000);
    expect_at(9, 3'b000, 3'b000, "R10 cancelled");
    tick(12);

    // R5 clash
    drive(3'b010, 3'b010);
    expect_at(10, 3'b000, 3'b000, "R5 both requested");
    tick(12);
    drive(3'b010, 3'b000);
    expect_at(3, 3'b010, 3'b000, "R3 phase1 high");
    tick(5);
    drive(3'b010, 3'b010);
    expect_at(3, 3'b000, 3'b000, "R5 clash turns off");
    tick(10);
    drive(3'b000, 3'b000);
    tick(10);

    // R4 xcond ignored in programmed mode
    xcond_en = 1'b1;
    drive(3'b100, 3'b100);
    expect_at(10, 3'b000, 3'b000, "R4 xcond ignored");
    tick(12);
    drive(3'b000, 3'b000); xcond_en = 1'b0;
    tick(10);

    // R6 D=0 still one idle cycle
    dt_count = 8'd0;
    drive(3'b100, 3'b000);
    expect_at(3, 3'b100, 3'b000, "R6 D0 high on");
    tick(6);
    drive(3'b000, 3'b100);
    expect_at(3, 3'b000, 3'b000, "R6 D0 gap");
    expect_at(4, 3'b000, 3'b100, "R6 D0 low on");
    tick(8);
    drive(3'b000, 3'b000);
    tick(10);

    // R11 high-side chop
    dt_count = 8'd5;
    drive(3'b001, 3'b000);
    tick(6);
    pwm_hs_en = 1'b0;
    expect_at(3, 3'b000, 3'b000, "R11 high off");
    expect_at(7, 3'b000, 3'b000, "R11 waiting");
    expect_at(8, 3'b000, 3'b001, "R11 sync rectification");
    tick(12);
    pwm_hs_en = 1'b1;
    expect_at(3, 3'b000, 3'b000, "R11 low released");
    expect_at(8, 3'b001, 3'b000, "R11 high restored");
    tick(12);

    // R12 low-side kill
    drive(3'b001, 3'b010);
    expect_at(3, 3'b001, 3'b010, "R3 mixed phases");
    tick(6);
    pwm_ls_en = 1'b0;
    expect_at(3, 3'b001, 3'b000, "R12 low off");
    tick(6);
    pwm_hs_en = 1'b0;
    expect_at(10, 3'b000, 3'b000, "R12 no rectification");
    tick(12);
    pwm_hs_en = 1'b1; pwm_ls_en = 1'b1; drive(3'b000, 3'b000);
    tick(20);

    // R7 default mode
    dt_mode = 2'b01;
    tick(320);
    drive(3'b100, 3'b000);
    expect_at(3, 3'b100, 3'b000, "R7 high on");
    tick(6);
    drive(3'b000, 3'b100);
    expect_at(3, 3'b000, 3'b000, "R7 high off");
    expect_at(302, 3'b000, 3'b000, "R7 default wait");
    expect_at(303, 3'b000, 3'b100, "R7 default low on");
    tick(310);
    drive(3'b000, 3'b000);
    tick(10);

    // R7 reserved code acts as default
    dt_mode = 2'b11;
    tick(310);
    drive(3'b100, 3'b000);
    expect_at(3, 3'b100, 3'b000, "R7 rsv high on");
    tick(6);
    drive(3'b000, 3'b100);
    expect_at(302, 3'b000, 3'b000, "R7 rsv wait");
    expect_at(303, 3'b000, 3'b100, "R7 rsv low on");
    tick(310);
    drive(3'b000, 3'b000);
    tick(10);

    // R8 disabled mode, R9 cross-conduction
    dt_mode = 2'b10;
    drive(3'b001, 3'b000);
    expect_at(3, 3'b001, 3'b000, "R8 high on");
    tick(6);
    drive(3'b000, 3'b001);
    expect_at(2, 3'b001, 3'b000, "R8 before switch");
    expect_at(3, 3'b000, 3'b001, "R8 same edge switch");
    tick(6);
    drive(3'b001, 3'b001);
    expect_at(3, 3'b000, 3'b000, "R5 lockout in disabled mode");
    tick(6);
    xcond_en = 1'b1;
    expect_at(1, 3'b001, 3'b001, "R9 both on");
    tick(4);
    xcond_en = 1'b0;
    expect_at(1, 3'b000, 3'b000, "R9 lockout back");
    tick(4);
    drive(3'b000, 3'b000);
    tick(5);
    dt_mode = 2'b00;
    tick(20);

    if (sb_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R2 scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule